// File: doc/BRIEF.md
# Trigger-word parameter RAM

This block holds a table of transfer descriptors, each eight 32-bit words, together with a small table of quick channels. Each quick channel names one descriptor and one word inside it, its trigger word. When the CPU stores to that exact word while the channel is enabled, the block emits a one-cycle trigger pulse carrying the channel number and the descriptor index. The data is stored in every case. No start register is involved. The descriptor words are, by word index: 0 options, 1 source address, 2 packed A count (bits 15:0) and B count (bits 31:16), 3 destination address, 4 packed B strides, 5 packed link address and B reload, 6 packed C strides, 7 C count.

The CPU addresses a word as `{descriptor index, word index}`, so word n of a set sits at byte offset n*4 from the set base. After reset, quick channel q points at descriptor `NUM_REG + q`, with the C count (word 7) as its trigger word, and every quick channel is disabled. The transfer engine can request a link update. A sequencer then copies all eight words of a source descriptor into a target descriptor. Every enabled quick channel mapped to the target then fires once.

The link sequencer has two states. In `LK_IDLE` it waits; `lnk_req` latches source and target and moves to `LK_COPY`. In `LK_COPY` it copies word `cnt` on every cycle; after word 7 it returns to `LK_IDLE` and raises the link-done request. Triggers from CPU writes and from link completion meet in a priority arbiter with a pending register.

Top module: `trig_param_ram`

## Requirements
- R1: After reset, `trig_valid` and `lnk_busy` are 0, all descriptor words read 0, every quick channel is disabled, and channel q maps to descriptor `NUM_REG+q` with trigger word 7 (C count).
- R2: A CPU write stores `cpu_wdata` at word `cpu_waddr` = {descriptor, word index 0..7}. A read presented on `cpu_raddr` returns the word on `cpu_rdata` after one clock edge.
- R3: A CPU write to the trigger word of an enabled channel's descriptor gives `trig_valid`=1 with that channel and descriptor for exactly one cycle, visible right after the write's clock edge.
- R4: A CPU write to any other word, or to the trigger word of a disabled channel, stores the data and produces no trigger.
- R5: A 1 on bit q of `en_set` enables channel q and a 1 on `en_clr` disables it. Zero bits have no effect, and clear wins when both are 1.
- R6: A map write sets a channel's descriptor index and trigger-word selector (0..7 = word index). Triggering follows the new mapping from the next cycle.
- R7: `lnk_req` in idle holds `lnk_busy` high for exactly 8 cycles while the 8 words of `lnk_src` are copied to `lnk_dst`.
- R8: After the last copied word, every enabled channel mapped to `lnk_dst` fires once. The first trigger is visible right after the 8th copy edge.
- R9: `lnk_req` while busy is ignored.
- R10: Triggers arriving in the same cycle go out one per cycle, lowest channel first. The others are held pending and issued in the following cycles in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU word write strobe |
| cpu_waddr | input | SET_W+3 | Write address {descriptor, word} |
| cpu_wdata | input | DW | Write data |
| cpu_raddr | input | SET_W+3 | Read address {descriptor, word} |
| cpu_rdata | output | DW | Registered read data |
| map_we | input | 1 | Quick-channel map write strobe |
| map_chan | input | Q_W | Channel being remapped |
| map_set | input | SET_W | New descriptor index |
| map_word | input | 3 | New trigger-word selector |
| en_set | input | NUM_Q | Write-1 enable bits |
| en_clr | input | NUM_Q | Write-1 disable bits |
| lnk_req | input | 1 | Link update request |
| lnk_src | input | SET_W | Source descriptor of the link copy |
| lnk_dst | input | SET_W | Target descriptor of the link copy |
| lnk_busy | output | 1 | Link copy in progress |
| trig_valid | output | 1 | Trigger pulse |
| trig_chan | output | Q_W | Triggered quick channel |
| trig_set | output | SET_W | Descriptor of the triggered channel |

## Verification
The assertions check on every cycle that clear wins over set on the enables, that a link copy steps through its word counter one word per cycle without losing its target, and that any outstanding trigger request produces a pulse on the next cycle while extra requests leave something pending. Only the bench scenarios can show the end-to-end effects. These are the stored and copied data, trigger addresses matched against remapped channels, the exact ascending order of simultaneous triggers, and the fact that a second link request during a copy leaves memory and triggers untouched.

// File: rtl/pram_pkg.sv
package pram_pkg;
    localparam int WORDS_PER_SET = 8;
    localparam int WSEL_W        = 3;

    typedef enum logic [WSEL_W-1:0] {
        WD_OPTIONS     = 3'd0,
        WD_SRC_ADDR    = 3'd1,
        WD_AB_COUNT    = 3'd2,
        WD_DST_ADDR    = 3'd3,
        WD_B_STRIDE    = 3'd4,
        WD_LINK_RELOAD = 3'd5,
        WD_C_STRIDE    = 3'd6,
        WD_C_COUNT     = 3'd7
    } pword_e;

    typedef enum logic {
        LK_IDLE = 1'b0,
        LK_COPY = 1'b1
    } lk_state_e;
endpackage

// File: rtl/qch_table.sv
module qch_table
    import pram_pkg::*;
#(
    parameter int NUM_Q   = 4,
    parameter int NUM_REG = 8,
    parameter int SET_W   = 4,
    parameter int Q_W     = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         map_we,
    input  logic [Q_W-1:0]               map_chan,
    input  logic [SET_W-1:0]             map_set,
    input  logic [WSEL_W-1:0]            map_word,
    input  logic [NUM_Q-1:0]             en_set,
    input  logic [NUM_Q-1:0]             en_clr,
    output logic [NUM_Q-1:0][SET_W-1:0]  q_set,
    output logic [NUM_Q-1:0][WSEL_W-1:0] q_word,
    output logic [NUM_Q-1:0]             q_en
);
    for (genvar q = 0; q < NUM_Q; q++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_set[q]  <= SET_W'(NUM_REG + q);
                q_word[q] <= WD_C_COUNT;
                q_en[q]   <= 1'b0;
            end else begin
                if (map_we && map_chan == Q_W'(q)) begin
                    q_set[q]  <= map_set;
                    q_word[q] <= map_word;
                end
                if (en_clr[q])      q_en[q] <= 1'b0;
                else if (en_set[q]) q_en[q] <= 1'b1;
            end
        end

        a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            en_clr[q] |=> !q_en[q]);
        a_r5_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
            (en_set[q] && !en_clr[q]) |=> q_en[q]);
    end
endmodule

// File: rtl/link_seq.sv
module link_seq
    import pram_pkg::*;
#(
    parameter int SET_W  = 4,
    parameter int ADDR_W = SET_W + WSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lnk_req,
    input  logic [SET_W-1:0]  lnk_src,
    input  logic [SET_W-1:0]  lnk_dst,
    output logic              busy,
    output logic              cp_we,
    output logic [ADDR_W-1:0] cp_raddr,
    output logic [ADDR_W-1:0] cp_waddr,
    output logic              done,
    output logic [SET_W-1:0]  done_set
);
    lk_state_e         state, state_n;
    logic [WSEL_W-1:0] cnt, cnt_n;
    logic [SET_W-1:0]  src_q, dst_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LK_IDLE;
            cnt   <= '0;
            src_q <= '0;
            dst_q <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            if (state == LK_IDLE && lnk_req) begin
                src_q <= lnk_src;
                dst_q <= lnk_dst;
            end
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            LK_IDLE: begin
                cnt_n = '0;
                if (lnk_req) state_n = LK_COPY;
            end
            LK_COPY: begin
                cnt_n = cnt + 3'd1;
                if (cnt == 3'(WORDS_PER_SET - 1)) state_n = LK_IDLE;
            end
        endcase
    end

    always_comb begin
        busy     = (state == LK_COPY);
        cp_we    = busy;
        cp_raddr = {src_q, cnt};
        cp_waddr = {dst_q, cnt};
        done     = busy && (cnt == 3'(WORDS_PER_SET - 1));
        done_set = dst_q;
    end

    a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_COPY && cnt != 3'(WORDS_PER_SET - 1)) |=>
        (state == LK_COPY && cnt == $past(cnt) + 3'd1));
    a_r9_hold_target: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_COPY) |=> $stable(dst_q));
endmodule

// File: rtl/trig_arb.sv
module trig_arb #(
    parameter int NUM_Q = 4,
    parameter int SET_W = 4,
    parameter int Q_W   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_Q-1:0]            req,
    input  logic [NUM_Q-1:0][SET_W-1:0] q_set,
    output logic                        trig_valid,
    output logic [Q_W-1:0]              trig_chan,
    output logic [SET_W-1:0]            trig_set
);
    logic [NUM_Q-1:0] pend, comb_req, grant;
    logic [Q_W-1:0]   gidx;
    logic             found;

    always_comb begin
        comb_req = pend | req;
        grant    = '0;
        gidx     = '0;
        found    = 1'b0;
        for (int i = 0; i < NUM_Q; i++) begin
            if (comb_req[i] && !found) begin
                grant[i] = 1'b1;
                gidx     = Q_W'(i);
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend       <= '0;
            trig_valid <= 1'b0;
            trig_chan  <= '0;
            trig_set   <= '0;
        end else begin
            pend       <= comb_req & ~grant;
            trig_valid <= found;
            trig_chan  <= gidx;
            trig_set   <= q_set[gidx];
        end
    end

    a_r10_serve: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend | req)) |=> trig_valid);
    a_r10_keep_rest: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pend | req) > 1) |=> (|pend));
endmodule

// File: rtl/trig_param_ram.sv
module trig_param_ram
    import pram_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int NUM_REG  = 8,
    parameter int NUM_Q    = 4,
    parameter int DW       = 32,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int ADDR_W  = SET_W + WSEL_W,
    localparam int DEPTH   = NUM_SETS * WORDS_PER_SET,
    localparam int Q_W     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_waddr,
    input  logic [DW-1:0]     cpu_wdata,
    input  logic [ADDR_W-1:0] cpu_raddr,
    output logic [DW-1:0]     cpu_rdata,
    input  logic              map_we,
    input  logic [Q_W-1:0]    map_chan,
    input  logic [SET_W-1:0]  map_set,
    input  logic [2:0]        map_word,
    input  logic [NUM_Q-1:0]  en_set,
    input  logic [NUM_Q-1:0]  en_clr,
    input  logic              lnk_req,
    input  logic [SET_W-1:0]  lnk_src,
    input  logic [SET_W-1:0]  lnk_dst,
    output logic              lnk_busy,
    output logic              trig_valid,
    output logic [Q_W-1:0]    trig_chan,
    output logic [SET_W-1:0]  trig_set
);
    logic [DW-1:0]                 mem [DEPTH];
    logic [NUM_Q-1:0][SET_W-1:0]   q_set;
    logic [NUM_Q-1:0][WSEL_W-1:0]  q_word;
    logic [NUM_Q-1:0]              q_en;
    logic [NUM_Q-1:0]              req;
    logic                          cp_we, lk_done;
    logic [ADDR_W-1:0]             cp_raddr, cp_waddr;
    logic [SET_W-1:0]              lk_done_set;

    qch_table #(.NUM_Q(NUM_Q), .NUM_REG(NUM_REG), .SET_W(SET_W), .Q_W(Q_W)) u_tab (
        .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_chan(map_chan),
        .map_set(map_set), .map_word(map_word), .en_set(en_set), .en_clr(en_clr),
        .q_set(q_set), .q_word(q_word), .q_en(q_en)
    );

    link_seq #(.SET_W(SET_W), .ADDR_W(ADDR_W)) u_lnk (
        .clk(clk), .rst_n(rst_n), .lnk_req(lnk_req), .lnk_src(lnk_src),
        .lnk_dst(lnk_dst), .busy(lnk_busy), .cp_we(cp_we), .cp_raddr(cp_raddr),
        .cp_waddr(cp_waddr), .done(lk_done), .done_set(lk_done_set)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_hit
        assign req[q] = q_en[q] &&
            ((cpu_we && cpu_waddr == {q_set[q], q_word[q]}) ||
             (lk_done && q_set[q] == lk_done_set));
    end

    trig_arb #(.NUM_Q(NUM_Q), .SET_W(SET_W), .Q_W(Q_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req), .q_set(q_set),
        .trig_valid(trig_valid), .trig_chan(trig_chan), .trig_set(trig_set)
    );

    // CPU write is applied last, so it wins over a copy to the same word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            cpu_rdata <= '0;
        end else begin
            if (cp_we)  mem[cp_waddr]  <= mem[cp_raddr];
            if (cpu_we) mem[cpu_waddr] <= cpu_wdata;
            cpu_rdata <= mem[cpu_raddr];
        end
    end
endmodule

// File: tb/trig_param_ram_test.sv
module trig_param_ram_test;
    localparam int NS = 16, NR = 8, NQ = 4, DW = 32;
    localparam int SW = 4, AW = 7, QW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_we = 0; logic [AW-1:0] cpu_waddr = '0; logic [DW-1:0] cpu_wdata = '0;
    logic [AW-1:0] cpu_raddr = '0; logic [DW-1:0] cpu_rdata;
    logic map_we = 0; logic [QW-1:0] map_chan = '0; logic [SW-1:0] map_set = '0;
    logic [2:0] map_word = '0;
    logic [NQ-1:0] en_set = '0, en_clr = '0;
    logic lnk_req = 0; logic [SW-1:0] lnk_src = '0, lnk_dst = '0;
    logic lnk_busy, trig_valid; logic [QW-1:0] trig_chan; logic [SW-1:0] trig_set;

    int tests = 0, fails = 0;
    logic [DW-1:0] mem_m [NS*8];
    logic [SW-1:0] set_m [NQ];
    logic [2:0]    word_m [NQ];
    logic [NQ-1:0] en_m;

    always #4 clk = ~clk;

    trig_param_ram uut (.*);

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    function automatic logic [NQ-1:0] hits(logic [AW-1:0] a);
        logic [NQ-1:0] m = '0;
        for (int q = 0; q < NQ; q++)
            if (en_m[q] && a == {set_m[q], word_m[q]}) m[q] = 1'b1;
        return m;
    endfunction

    task automatic expect_trigs(string r, logic [NQ-1:0] m);
        for (int q = 0; q < NQ; q++) begin
            if (m[q]) begin
                chk(r, {trig_valid, 29'd0, 2'(trig_chan)}, {1'b1, 29'd0, 2'(q)});
                chk(r, 32'(trig_set), 32'(set_m[q]));
                step();
            end
        end
        chk(r, 32'(trig_valid), 32'd0);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, string r);
        logic [NQ-1:0] m = hits(a);
        cpu_we = 1; cpu_waddr = a; cpu_wdata = d;
        step();
        cpu_we = 0;
        mem_m[a] = d;
        expect_trigs(r, m);
    endtask

    task automatic rd(logic [AW-1:0] a, string r);
        cpu_raddr = a; step();
        chk(r, cpu_rdata, mem_m[a]);
    endtask

    task automatic en_op(logic [NQ-1:0] s, logic [NQ-1:0] c);
        en_set = s; en_clr = c; step(); en_set = '0; en_clr = '0;
        en_m = (en_m | s) & ~c;
    endtask

    task automatic remap(int q, logic [SW-1:0] s, logic [2:0] w);
        map_we = 1; map_chan = QW'(q); map_set = s; map_word = w; step(); map_we = 0;
        set_m[q] = s; word_m[q] = w;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NS*8; i++) mem_m[i] = '0;
        for (int q = 0; q < NQ; q++) begin set_m[q] = SW'(NR + q); word_m[q] = 3'd7; end
        en_m = '0;
        repeat (3) step();
        rst_n = 1; #1;
        // R1 reset state
        chk("R1", 32'(trig_valid), 0);
        chk("R1", 32'(lnk_busy), 0);
        rd(AW'(37), "R1");
        // R4 disabled channel, R2 storage
        wr({4'd8, 3'd7}, 32'hA5A5_0001, "R4");
        rd({4'd8, 3'd7}, "R2");
        // R3 default map triggers once after enable
        en_op(4'b0001, 4'b0000);
        wr({4'd8, 3'd7}, 32'h0000_0010, "R3");
        wr({4'd8, 3'd3}, 32'hDEAD_BEEF, "R4");
        rd({4'd8, 3'd3}, "R4");
        // R5 clear wins, zero masks no effect
        en_op(4'b0001, 4'b0001);
        wr({4'd8, 3'd7}, 32'h11, "R5");
        en_op(4'b0010, 4'b0000);
        en_op(4'b0000, 4'b0000);
        wr({4'd9, 3'd7}, 32'h22, "R5");
        // R6 remap
        remap(2, 4'd3, 3'd2);
        en_op(4'b0100, 4'b0000);
        wr({4'd3, 3'd2}, 32'h0004_0008, "R6");
        wr({4'd10, 3'd7}, 32'h33, "R6");
        // R10 two channels same word
        remap(3, 4'd3, 3'd2);
        en_op(4'b1000, 4'b0000);
        wr({4'd3, 3'd2}, 32'h0002_0040, "R10");
        // R7/R8/R9 link copy set1 -> set9 (ch1 enabled there)
        for (int w = 0; w < 8; w++) wr({4'd1, 3'(w)}, 32'hC0DE_0000 + 32'(w), "R7");
        lnk_req = 1; lnk_src = 4'd1; lnk_dst = 4'd9; step(); lnk_req = 0;
        chk("R7", 32'(lnk_busy), 1);
        for (int i = 1; i < 8; i++) begin
            if (i == 3) begin lnk_req = 1; lnk_src = 4'd2; lnk_dst = 4'd3; end
            step();
            lnk_req = 0;
            chk("R7", 32'(lnk_busy), 1);
            chk("R8", 32'(trig_valid), 0);
        end
        step();
        chk("R7", 32'(lnk_busy), 0);
        for (int w = 0; w < 8; w++) mem_m[{4'd9, 3'(w)}] = mem_m[{4'd1, 3'(w)}];
        expect_trigs("R8", 4'b0010);
        repeat (12) begin
            step();
            chk("R9", 32'(trig_valid | lnk_busy), 0);
        end
        for (int w = 0; w < 8; w++) rd({4'd9, 3'(w)}, "R7");
        rd({4'd3, 3'd2}, "R9");
        // random mix
        for (int it = 0; it < 300; it++) begin
            logic [AW-1:0] a;
            if ($urandom % 4 == 0) en_op(NQ'($urandom), NQ'($urandom));
            if ($urandom % 2 == 0) begin
                int q = int'($urandom % NQ);
                a = {set_m[q], word_m[q]};
            end else a = AW'($urandom);
            wr(a, $urandom, "R3");
            rd(a, "R2");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule